// File: doc/BRIEF.md
# Interlocked two-phase PWM generator

This block drives two pulse-width-modulated phases from one center-aligned up/down counter. Each phase has its own on-time setting, so both can run at the same low duty. They are not complementary, where one is the inverse of the other. Phase A is placed at the start of the up-counting half of the period. Phase B is placed at the start of the down-counting half. A dead-time setting holds both phases low between the fall of one and the rise of the other, and it does not depend on the duty values.

Two hardware mechanisms keep the outputs safe whatever values are requested. First, every requested on-time is clamped to the half period minus the dead time, and a flag reports when clamping took place. Second, a final gate never lets both phases be high together, and it keeps a phase low until enough idle cycles have passed since the other phase fell. All settings are captured into shadow registers only at the counter's bottom point, so a write in the middle of a period never alters the period in progress.

Top module: `pwm2_top`

## Requirements
- R1: `pwm_a_o` and `pwm_b_o` are never both 1 in the same cycle, for any input values.
- R2: With shadow period P, the counter steps up 0..P-1 and then down P..1, so each period lasts 2P cycles. `pwm_a_o` is high for the first dA cycles of each period, where dA is the effective duty of phase A.
- R3: `pwm_b_o` is high for the first dB cycles of the down-counting half, where dB is the effective duty of phase B. Equal duty settings give equal on-times on both phases.
- R4: Each effective duty is min(request, P - dead). It is 0 when dead >= P. So a request of more than half a period still yields non-overlapping pulses.
- R5: `clamp_o` is 1 while the shadow set in force had at least one duty request above its limit, and 0 otherwise.
- R6: An output goes from 0 to 1 only if it was itself the last output that was high, or if at least `dead_i` (shadow) cycles with both outputs low have passed since the other output was last high.
- R7: Period, duties and dead time are captured only on the clock edge that returns the counter to 0, or on any edge while disabled. A write at any other time has no effect on the period in progress.
- R8: While reset is asserted, or on any edge with `en_i` = 0, both outputs are driven to 0 and the counter is held at 0, counting up.
- R9: A `period_i` value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| period_i | input | CNT_W | Half period P in cycles |
| duty_a_i | input | CNT_W | Requested on-time of phase A, in cycles |
| duty_b_i | input | CNT_W | Requested on-time of phase B, in cycles |
| dead_i | input | DT_W | Dead time in cycles |
| pwm_a_o | output | 1 | Phase A output |
| pwm_b_o | output | 1 | Phase B output |
| clamp_o | output | 1 | A duty request of the current set was clamped |

## Verification
The bench builds the block with CNT_W = 8 and DT_W = 5. With these widths, periods of a few dozen cycles repeat many times in a short run. Dead-time values reach and exceed the half period, so the clamp-to-zero case and the guard that suppresses a whole pulse are both exercised. Random writes land at arbitrary counter positions, and enable is toggled in the middle of pulses. Directed cases cover the minimum period, requests of more than half a period, a capture right after a pulse edge, and a dead-time increase that the guard must catch.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/pwm2_shadow.sv
module pwm2_shadow #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_a_i,
  input  logic [CNT_W-1:0] duty_b_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_a_o,
  output logic [CNT_W-1:0] duty_b_o,
  output logic [DT_W-1:0]  dead_o,
  output logic             clamp_o
);
  localparam int SW = CNT_W + 1;
  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(2);

  logic [CNT_W-1:0] per_in, dead_ext, lim, da, db;
  logic             over_a, over_b;

  always_comb begin
    per_in   = (period_i < PER_MIN) ? PER_MIN : period_i;
    dead_ext = CNT_W'(dead_i);
    lim      = (dead_ext >= per_in) ? '0 : per_in - dead_ext;
    over_a   = duty_a_i > lim;
    over_b   = duty_b_i > lim;
    da       = over_a ? lim : duty_a_i;
    db       = over_b ? lim : duty_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o    <= PER_MIN;
      duty_a_o <= '0;
      duty_b_o <= '0;
      dead_o   <= '0;
      clamp_o  <= 1'b0;
    end else if (load_i) begin
      per_o    <= per_in;
      duty_a_o <= da;
      duty_b_o <= db;
      dead_o   <= dead_i;
      clamp_o  <= over_a | over_b;
    end
  end

  p_clamp_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_a_o == '0 || SW'(duty_a_o) + SW'(dead_o) <= SW'(per_o)) &&
    (duty_b_o == '0 || SW'(duty_b_o) + SW'(dead_o) <= SW'(per_o)));
  p_per_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_o >= PER_MIN);
  p_shadow_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(per_o) && $stable(duty_a_o) && $stable(duty_b_o)
                && $stable(dead_o) && $stable(clamp_o));
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output pwm2_pkg::dir_e   dir_o,
  output logic             load_o
);
  import pwm2_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // capture point: edge that returns the counter to bottom, or idle
  assign load_o = !en_i || (dir_o == DIR_DN && cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_o <= DIR_UP;
    end else if (!en_i) begin
      cnt_o <= '0;
      dir_o <= DIR_UP;
    end else if (dir_o == DIR_UP) begin
      if (cnt_o == per_i - ONE) begin
        cnt_o <= per_i;
        dir_o <= DIR_DN;
      end else begin
        cnt_o <= cnt_o + ONE;
      end
    end else begin
      if (cnt_o == ONE) dir_o <= DIR_UP;
      cnt_o <= cnt_o - ONE;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= per_i);
  p_top_turn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dir_o == DIR_UP && cnt_o == per_i - ONE |=> dir_o == DIR_DN && cnt_o == $past(per_i));
  p_hold_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0 && dir_o == DIR_UP);
endmodule

// File: rtl/pwm2_gate.sv
module pwm2_gate #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            raw_a_i,
  input  logic            raw_b_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            pwm_a_o,
  output logic            pwm_b_o
);
  logic [DT_W-1:0] idle_q;
  logic            last_a_q;
  logic            gap_ok, a_d, b_d;

  assign gap_ok = idle_q >= dead_i;
  assign a_d = en_i && raw_a_i && !raw_b_i && (last_a_q || gap_ok);
  assign b_d = en_i && raw_b_i && !raw_a_i && (!last_a_q || gap_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_a_o  <= 1'b0;
      pwm_b_o  <= 1'b0;
      idle_q   <= '1;
      last_a_q <= 1'b0;
    end else begin
      pwm_a_o <= a_d;
      pwm_b_o <= b_d;
      if (a_d || b_d) begin
        idle_q   <= '0;
        last_a_q <= a_d;
      end else if (idle_q != '1) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_a_o && pwm_b_o));
  p_dead_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_a_o) |-> $past(last_a_q) || $past(idle_q) >= $past(dead_i));
  p_dead_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_b_o) |-> !$past(last_a_q) || $past(idle_q) >= $past(dead_i));
  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_a_o && !pwm_b_o);
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_a_i,
  input  logic [CNT_W-1:0] duty_b_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             clamp_o
);
  import pwm2_pkg::*;

  logic [CNT_W-1:0] per_s, duty_a_s, duty_b_s, cnt;
  logic [DT_W-1:0]  dead_s;
  dir_e             dir;
  logic             load, raw_a, raw_b;

  pwm2_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .per_i (per_s),
    .cnt_o (cnt),
    .dir_o (dir),
    .load_o(load)
  );

  pwm2_shadow #(.CNT_W(CNT_W), .DT_W(DT_W)) u_shd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .period_i(period_i),
    .duty_a_i(duty_a_i),
    .duty_b_i(duty_b_i),
    .dead_i  (dead_i),
    .per_o   (per_s),
    .duty_a_o(duty_a_s),
    .duty_b_o(duty_b_s),
    .dead_o  (dead_s),
    .clamp_o (clamp_o)
  );

  // A leads the up half, B leads the down half
  assign raw_a = (dir == DIR_UP) && (cnt < duty_a_s);
  assign raw_b = (dir == DIR_DN) && (cnt > per_s - duty_b_s);

  pwm2_gate #(.DT_W(DT_W)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .raw_a_i(raw_a),
    .raw_b_i(raw_b),
    .dead_i (dead_s),
    .pwm_a_o(pwm_a_o),
    .pwm_b_o(pwm_b_o)
  );

  p_halves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raw_a && raw_b));
endmodule

// File: tb/sim_pwm2_top.sv
module sim_pwm2_top;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int DW = 5;
  localparam int IDLE_MAX = (1 << DW) - 1;

  logic clk = 0, rst_n = 0, en = 0;
  logic [CW-1:0] period = 8'd10, duty_a = 0, duty_b = 0;
  logic [DW-1:0] dead = 0;
  logic pwm_a, pwm_b, clamp;

  int total = 0, bad = 0;
  bit finished = 0, chk_on = 0;

  pwm2_top #(.CNT_W(CW), .DT_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period),
    .duty_a_i(duty_a), .duty_b_i(duty_b), .dead_i(dead),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .clamp_o(clamp));

  always #(CLK_P/2) clk = ~clk;

  // requirement-level model
  int m_cnt, m_per, m_da, m_db, m_dt, m_idle;
  bit m_up, m_la, e_a, e_b, e_c;

  function automatic int eff(int req, int p, int d);
    int lim = (d >= p) ? 0 : p - d;
    return (req > lim) ? lim : req;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_per = 2; m_da = 0; m_db = 0; m_dt = 0;
      m_idle = IDLE_MAX; m_la = 0; e_a = 0; e_b = 0; e_c = 0;
    end else begin
      bit ld, na, nb;
      int p;
      ld = !en || (!m_up && m_cnt == 1);
      na = en && m_up && (m_cnt < m_da) && (m_la || m_idle >= m_dt);
      nb = en && !m_up && (m_cnt > m_per - m_db) && (!m_la || m_idle >= m_dt);
      if (na || nb) begin m_idle = 0; m_la = na; end
      else if (m_idle < IDLE_MAX) m_idle++;
      if (!en) begin m_cnt = 0; m_up = 1; end
      else if (m_up) begin
        if (m_cnt == m_per - 1) begin m_cnt = m_per; m_up = 0; end
        else m_cnt++;
      end else begin
        if (m_cnt == 1) m_up = 1;
        m_cnt--;
      end
      if (ld) begin
        p = (int'(period) < 2) ? 2 : int'(period);
        m_per = p;
        m_dt = int'(dead);
        m_da = eff(int'(duty_a), p, m_dt);
        m_db = eff(int'(duty_b), p, m_dt);
        e_c = (int'(duty_a) > m_da) || (int'(duty_b) > m_db);
      end
      e_a = na; e_b = nb;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on && !finished) begin
      chk(pwm_a == e_a, en ? "R2 R6 pwm_a" : "R8 pwm_a", pwm_a, e_a);
      chk(pwm_b == e_b, en ? "R3 R6 pwm_b" : "R8 pwm_b", pwm_b, e_b);
      chk(clamp == e_c, "R5 clamp", clamp, e_c);
      chk(!(pwm_a && pwm_b), "R1 overlap", pwm_a & pwm_b, 0);
    end
  end

  task automatic set(int p, int a, int b, int d);
    period = CW'(p); duty_a = CW'(a); duty_b = CW'(b); dead = DW'(d);
  endtask

  task automatic count(int n, output int ca, output int cb);
    ca = 0; cb = 0;
    repeat (n) begin
      @(negedge clk);
      ca += int'(pwm_a); cb += int'(pwm_b);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ca, cb;
    bit prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(pwm_a == 0 && pwm_b == 0 && clamp == 0, "R8 reset", {pwm_a, pwm_b, clamp}, 0);
    rst_n = 1;
    chk_on = 1;

    // both phases 20% of period
    set(10, 4, 4, 1); en = 1;
    repeat (60) @(negedge clk);
    count(20, ca, cb);
    chk(ca == 4, "R2 equal duty A", ca, 4);
    chk(cb == 4, "R3 equal duty B", cb, 4);

    // request above half period on both
    set(10, 12, 12, 2);
    repeat (60) @(negedge clk);
    count(20, ca, cb);
    chk(ca == 8 && cb == 8, "R4 clamp to P-dead", ca * 100 + cb, 808);
    chk(clamp == 1, "R5 flag set", clamp, 1);

    // dead time swallows the whole half period
    set(10, 5, 5, 12);
    repeat (60) @(negedge clk);
    count(20, ca, cb);
    chk(ca == 0 && cb == 0, "R4 dead>=P gives zero", ca + cb, 0);

    // minimum period
    set(1, 1, 1, 0);
    repeat (20) @(negedge clk);
    count(4, ca, cb);
    chk(ca == 1 && cb == 1, "R9 period floor", ca * 10 + cb, 11);
    chk(clamp == 0, "R5 flag clear", clamp, 0);

    // mid-period write must wait for bottom
    set(20, 5, 3, 2);
    repeat (100) @(negedge clk);
    prev = pwm_a;
    while (!( !prev && pwm_a)) begin prev = pwm_a; @(negedge clk); end
    duty_a = 8'd15;
    count(19, ca, cb);
    chk(ca == 4, "R7 pulse kept old duty", ca + 1, 5);
    repeat (40) @(negedge clk);
    count(40, ca, cb);
    chk(ca == 15, "R7 new duty after bottom", ca, 15);

    // dead-time raise: guard suppresses A after short B gap
    set(10, 2, 8, 2);
    repeat (80) @(negedge clk);
    prev = pwm_b;
    while (!(prev && !pwm_b)) begin prev = pwm_b; @(negedge clk); end
    dead = 5'd6;
    count(10, ca, cb);
    chk(ca == 0, "R6 guard blocks A", ca, 0);
    count(20, ca, cb);
    chk(ca == 2 && cb == 4, "R6 recovery", ca * 10 + cb, 24);

    // disable mid-pulse
    en = 0;
    @(negedge clk);
    chk(pwm_a == 0 && pwm_b == 0, "R8 disable", pwm_a | pwm_b, 0);
    repeat (40) @(negedge clk);
    en = 1;

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      int gap = 1 + int'($urandom_range(0, 59));
      int pr = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(2, 40));
      set(pr, int'($urandom_range(0, 45)), int'($urandom_range(0, 45)), int'($urandom_range(0, 31)));
      if ($urandom_range(0, 29) == 0) en = ~en;
      else if (!en && $urandom_range(0, 1) == 0) en = 1;
      repeat (gap) @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule